// File: doc/BRIEF.md
# Frequency-Locked Loop Controller

This block is the digital half of a frequency-locked loop that holds an on-chip digitally controlled oscillator (DCO) at a fixed multiple of a slow, stable reference clock. In the DCO domain it counts oscillator cycles between two reference rising edges. It then hands the count across to the reference domain with a toggle handshake. There the count is compared with the target. The target is (N+1) times the reference frequency. When the extended-range flag is set, it is (N+1) times a power-of-two factor D instead. A 10-bit frequency integrator then moves by one count toward the target. If the count equals the target, the integrator does not move.

The integrator's five upper bits choose a coarse oscillator tap. Its five lower bits are a fractional word. A phase accumulator in the DCO domain turns that word into a per-cycle "use the next faster tap" select, and it spreads those cycles as evenly as it can. Software may overwrite the integrator at any time. Writing zero restarts the loop from the slowest tap with no fractional part. The analog oscillator is outside the block. It takes `tap_o` and `tap_up_o` and returns `dco_clk_i`. The recommended configuration after reset is N = 31, D = 2 and the extended-range flag clear, which gives 32 times the reference frequency.

Top module: `fll_ctrl`

## Requirements
- R1: While rst_ni is low, integ_o, tap_o and tap_up_o are all zero.
- R2: Each completed measurement changes the integrator by exactly one count. It goes down when the DCO count exceeds the target and up when the count is below it.
- R3: The target is mult_n_i+1 when mult_plus_i is 0, and (mult_n_i+1) shifted left by div_sel_i (D = 1, 2, 4, 8 for codes 0 to 3) when mult_plus_i is 1.
- R4: The integrator saturates: it stays at 0 when asked to step down and at 1023 when asked to step up, and never wraps.
- R5: tap_o equals integ_o[9:5], limited to 28, so codes 28 to 31 all give tap 28. tap_up_o is never high while tap_o is 28.
- R6: When the DCO count equals the target, the integrator keeps its value.
- R7: With a constant integrator below tap 28, tap_up_o is high on exactly integ[4:0] cycles out of any 32 consecutive DCO cycles.
- R8: When integ[4:0] is 16 or less, tap_up_o is never high on two consecutive DCO cycles.
- R9: A write (wr_en_i high at a reference edge) loads wr_data_i into the integrator and takes priority over a step. Writing zero yields tap 0 and no tap_up_o pulses.
- R10: With an oscillator whose period falls steadily with tap and select, the loop settles so that the DCO produces the target count, within a few cycles, per reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; the integrator and the write port run on it |
| dco_clk_i | input | 1 | Oscillator clock fed back from the DCO |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| mult_n_i | input | 7 | Multiplier field N |
| div_sel_i | input | 2 | Extra factor D code: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8 |
| mult_plus_i | input | 1 | Applies D to the target when high |
| wr_en_i | input | 1 | Integrator write strobe (reference domain) |
| wr_data_i | input | 10 | Integrator write value |
| integ_o | output | 10 | Integrator readback (reference domain) |
| tap_o | output | 5 | Coarse DCO tap, 0 to 28 |
| tap_up_o | output | 1 | Per-DCO-cycle select for tap_o+1 |

## Verification
The bench builds the block with its default parameters: a 10-bit integrator, a 5-bit tap with ceiling 28, a 12-bit count and a 7-bit N. With these, both saturation ends, tap codes above the ceiling and every fractional value from 0 to 31 can be reached by direct writes. The bench drives a DCO period that is exactly 1/32 of the reference period. This gives exact equality with the target, so the integrator holds still while the fractional pattern is counted frame by frame. Halving or doubling that period forces steady downward or upward stepping. A final closed-loop run lets a tap-to-period model drive the oscillator and checks where the loop settles.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int unsigned FLL_INT_W   = 10;
  localparam int unsigned FLL_TAP_W   = 5;
  localparam int unsigned FLL_MAX_TAP = 28;
  localparam int unsigned FLL_N_W     = 7;
  localparam int unsigned FLL_DIV_W   = 2;
  localparam int unsigned FLL_CNT_W   = 12;
  localparam int unsigned FLL_SYNC_N  = 2;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/fll_meas.sv
module fll_meas #(
  parameter int unsigned CNT_W  = fll_pkg::FLL_CNT_W,
  parameter int unsigned SYNC_N = fll_pkg::FLL_SYNC_N
) (
  input  logic             dco_clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             req_tgl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N:0]  ref_sync_q;
  logic             ref_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] meas_q;
  logic             req_q;

  always_ff @(posedge dco_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_sync_q <= '0;
    else         ref_sync_q <= {ref_sync_q[SYNC_N-1:0], ref_clk_i};
  end

  assign ref_rise = ref_sync_q[SYNC_N-1] & ~ref_sync_q[SYNC_N];

  // window closes on the cycle the reference edge is seen; that cycle counts
  always_ff @(posedge dco_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      meas_q <= '0;
      req_q  <= 1'b0;
    end else if (ref_rise) begin
      meas_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      cnt_q  <= '0;
      req_q  <= ~req_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign meas_o    = meas_q;
  assign req_tgl_o = req_q;

  AST_MEAS_HELD: assert property (@(posedge dco_clk_i) disable iff (!rst_ni)
    !ref_rise |=> ($stable(meas_q) && $stable(req_q))); // R2
endmodule

// File: rtl/fll_integ.sv
module fll_integ
  import fll_pkg::*;
#(
  parameter int unsigned INT_W  = FLL_INT_W,
  parameter int unsigned N_W    = FLL_N_W,
  parameter int unsigned DIV_W  = FLL_DIV_W,
  parameter int unsigned CNT_W  = FLL_CNT_W,
  parameter int unsigned SYNC_N = FLL_SYNC_N
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             req_tgl_i,
  input  logic [N_W-1:0]   mult_n_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             mult_plus_i,
  input  logic             wr_en_i,
  input  logic [INT_W-1:0] wr_data_i,
  output logic [INT_W-1:0] integ_o,
  output logic             ack_tgl_o
);
  localparam int unsigned TGT_W = N_W + 1 + (2**DIV_W - 1);
  localparam int unsigned CMP_W = (CNT_W > TGT_W) ? CNT_W : TGT_W;
  localparam logic [INT_W-1:0] INT_MAX = {INT_W{1'b1}};

  logic [SYNC_N:0]  req_sync_q;
  logic             upd;
  logic [TGT_W-1:0] base;
  logic [TGT_W-1:0] target;
  logic [CMP_W-1:0] meas_x;
  logic [CMP_W-1:0] tgt_x;
  step_e            step;
  logic [INT_W-1:0] integ_q;
  logic             ack_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) req_sync_q <= '0;
    else         req_sync_q <= {req_sync_q[SYNC_N-1:0], req_tgl_i};
  end

  assign upd = req_sync_q[SYNC_N-1] ^ req_sync_q[SYNC_N];

  assign base   = TGT_W'(mult_n_i) + TGT_W'(1);
  assign target = mult_plus_i ? (base << div_sel_i) : base;
  assign meas_x = CMP_W'(meas_i);
  assign tgt_x  = CMP_W'(target);

  // DCO too fast -> lower the integrator
  always_comb begin
    if (meas_x > tgt_x)      step = STEP_DN;
    else if (meas_x < tgt_x) step = STEP_UP;
    else                     step = STEP_HOLD;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
    end else if (wr_en_i) begin
      integ_q <= wr_data_i;
    end else if (upd) begin
      unique case (step)
        STEP_UP:   if (integ_q != INT_MAX) integ_q <= integ_q + 1'b1;
        STEP_DN:   if (integ_q != '0)      integ_q <= integ_q - 1'b1;
        default:   integ_q <= integ_q;
      endcase
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)  ack_q <= 1'b0;
    else if (upd) ack_q <= ~ack_q;
  end

  assign integ_o   = integ_q;
  assign ack_tgl_o = ack_q;

  AST_STEP_ONE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (integ_q == $past(integ_q) ||
                  (integ_q != '0 && integ_q - 1'b1 == $past(integ_q)) ||
                  (integ_q != INT_MAX && integ_q + 1'b1 == $past(integ_q)))); // R2
  AST_NO_WRAP_HI: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (integ_q == INT_MAX && !wr_en_i) |=> integ_q != '0); // R4
  AST_NO_WRAP_LO: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (integ_q == '0 && !wr_en_i) |=> integ_q != INT_MAX); // R4
  AST_EQ_HOLD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (upd && meas_x == tgt_x && !wr_en_i) |=> $stable(integ_q)); // R6
  AST_WR_LOAD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    wr_en_i |=> integ_q == $past(wr_data_i)); // R9
endmodule

// File: rtl/fll_mod.sv
module fll_mod #(
  parameter int unsigned INT_W   = fll_pkg::FLL_INT_W,
  parameter int unsigned TAP_W   = fll_pkg::FLL_TAP_W,
  parameter int unsigned MAX_TAP = fll_pkg::FLL_MAX_TAP,
  parameter int unsigned SYNC_N  = fll_pkg::FLL_SYNC_N
) (
  input  logic             dco_clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] integ_i,
  input  logic             ack_tgl_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_up_o
);
  localparam int unsigned MOD_W = INT_W - TAP_W;
  localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(MAX_TAP);
  localparam logic [MOD_W-1:0] MOD_HALF = MOD_W'(2**(MOD_W-1));

  logic [SYNC_N:0]  ack_sync_q;
  logic             load;
  logic [INT_W-1:0] snap_q;
  logic [TAP_W-1:0] tap_raw;
  logic [MOD_W-1:0] mod;
  logic             at_top;
  logic [MOD_W-1:0] acc_q;
  logic [MOD_W:0]   sum;
  logic [TAP_W-1:0] tap_q;
  logic             up_q;

  always_ff @(posedge dco_clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_sync_q <= '0;
    else         ack_sync_q <= {ack_sync_q[SYNC_N-1:0], ack_tgl_i};
  end

  assign load = ack_sync_q[SYNC_N-1] ^ ack_sync_q[SYNC_N];

  // integrator is stable between an ack and the next request
  always_ff @(posedge dco_clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (load) snap_q <= integ_i;
  end

  assign tap_raw = snap_q[INT_W-1:MOD_W];
  assign mod     = snap_q[MOD_W-1:0];
  assign at_top  = tap_raw >= TAP_TOP;
  assign sum     = {1'b0, acc_q} + {1'b0, mod};

  always_ff @(posedge dco_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      up_q  <= 1'b0;
      tap_q <= '0;
    end else if (at_top) begin
      acc_q <= '0;
      up_q  <= 1'b0;
      tap_q <= TAP_TOP;
    end else begin
      acc_q <= sum[MOD_W-1:0];
      up_q  <= sum[MOD_W];
      tap_q <= tap_raw;
    end
  end

  assign tap_o    = tap_q;
  assign tap_up_o = up_q;

  AST_TOP_NO_UP: assert property (@(posedge dco_clk_i) disable iff (!rst_ni)
    (tap_q == TAP_TOP) |-> !up_q); // R5
  AST_TAP_CEIL: assert property (@(posedge dco_clk_i) disable iff (!rst_ni)
    (snap_q[INT_W-1:MOD_W] >= TAP_TOP) |=> (tap_q == TAP_TOP || $past(load))); // R5
  AST_SPREAD: assert property (@(posedge dco_clk_i) disable iff (!rst_ni)
    (up_q && $stable(mod) && mod <= MOD_HALF) |=> !up_q); // R8
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl
  import fll_pkg::*;
#(
  parameter int unsigned INT_W   = FLL_INT_W,
  parameter int unsigned TAP_W   = FLL_TAP_W,
  parameter int unsigned MAX_TAP = FLL_MAX_TAP,
  parameter int unsigned N_W     = FLL_N_W,
  parameter int unsigned DIV_W   = FLL_DIV_W,
  parameter int unsigned CNT_W   = FLL_CNT_W,
  parameter int unsigned SYNC_N  = FLL_SYNC_N
) (
  input  logic             ref_clk_i,
  input  logic             dco_clk_i,
  input  logic             rst_ni,
  input  logic [N_W-1:0]   mult_n_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             mult_plus_i,
  input  logic             wr_en_i,
  input  logic [INT_W-1:0] wr_data_i,
  output logic [INT_W-1:0] integ_o,
  output logic [TAP_W-1:0] tap_o,
  output logic             tap_up_o
);
  logic [CNT_W-1:0] meas;
  logic             req_tgl;
  logic             ack_tgl;

  fll_meas #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_meas (
    .dco_clk_i (dco_clk_i),
    .rst_ni    (rst_ni),
    .ref_clk_i (ref_clk_i),
    .meas_o    (meas),
    .req_tgl_o (req_tgl)
  );

  fll_integ #(
    .INT_W(INT_W), .N_W(N_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .SYNC_N(SYNC_N)
  ) u_integ (
    .ref_clk_i   (ref_clk_i),
    .rst_ni      (rst_ni),
    .meas_i      (meas),
    .req_tgl_i   (req_tgl),
    .mult_n_i    (mult_n_i),
    .div_sel_i   (div_sel_i),
    .mult_plus_i (mult_plus_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .integ_o     (integ_o),
    .ack_tgl_o   (ack_tgl)
  );

  fll_mod #(
    .INT_W(INT_W), .TAP_W(TAP_W), .MAX_TAP(MAX_TAP), .SYNC_N(SYNC_N)
  ) u_mod (
    .dco_clk_i (dco_clk_i),
    .rst_ni    (rst_ni),
    .integ_i   (integ_o),
    .ack_tgl_i (ack_tgl),
    .tap_o     (tap_o),
    .tap_up_o  (tap_up_o)
  );
endmodule

// File: tb/test_fll_ctrl.sv
`timescale 1ns/1ps
module test_fll_ctrl;
  localparam realtime REF_PERIOD = 3200.0;

  typedef struct {
    int    tap_exp;
    int    ups_exp;
    bit    spread;
  } sb_item_t;

  logic       ref_clk, dco_clk, rst_n;
  logic [6:0] mult_n;
  logic [1:0] div_sel;
  logic       mult_plus, wr_en;
  logic [9:0] wr_data;
  logic [9:0] integ;
  logic [4:0] tap;
  logic       tap_up;

  realtime dco_half = 50.0;
  bit      model_en = 0;
  int      n_chk = 0, n_fail = 0, sb_done = 0;
  int      dco_edges = 0;
  bit      finished = 0;
  sb_item_t sb_q[$];

  fll_ctrl i_fll_ctrl (
    .ref_clk_i(ref_clk), .dco_clk_i(dco_clk), .rst_ni(rst_n),
    .mult_n_i(mult_n), .div_sel_i(div_sel), .mult_plus_i(mult_plus),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .integ_o(integ), .tap_o(tap), .tap_up_o(tap_up)
  );

  initial begin
    ref_clk = 0;
    forever #(REF_PERIOD/2) ref_clk = ~ref_clk;
  end

  // oscillator: fixed period, or a model where higher tap means shorter period
  initial begin
    dco_clk = 0;
    #7;
    forever begin
      if (model_en) dco_half = (200.0 - 4.0 * real'(int'(tap) + int'(tap_up))) / 2.0;
      #(dco_half) dco_clk = ~dco_clk;
    end
  end

  always @(posedge dco_clk) dco_edges++;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic write_integ(input int v);
    @(negedge ref_clk);
    wr_en = 1; wr_data = 10'(v);
    @(negedge ref_clk);
    wr_en = 0;
  endtask

  task automatic watch_steps(input string req, input int dir, input int n);
    int prev = int'(integ);
    bit bad = 0;
    int badv = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge ref_clk);
      if (int'(integ) != prev) begin
        if (int'(integ) - prev != dir) begin bad = 1; badv = int'(integ) - prev; end
        prev = int'(integ);
      end
    end
    chk(req, !bad, badv, dir);
  endtask

  // scoreboard driver
  task automatic sb_push(input int v);
    sb_item_t it;
    int t = v >> 5;
    it.tap_exp = (t > 28) ? 28 : t;
    it.ups_exp = (t >= 28) ? 0 : (v & 31);
    it.spread  = (v & 31) <= 16;
    write_integ(v);
    wait_ref(1);
    chk("R9", integ == 10'(v), int'(integ), v);
    wait_ref(4);
    sb_q.push_back(it);
    wait (sb_done == n_sb_pushed + 1);
    n_sb_pushed++;
  endtask
  int n_sb_pushed = 0;

  // scoreboard monitor
  initial begin
    forever begin
      sb_item_t it;
      int ups, run, maxrun;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      @(negedge dco_clk);
      chk("R5", int'(tap) == it.tap_exp, int'(tap), it.tap_exp);
      ups = 0; run = 0; maxrun = 0;
      for (int i = 0; i < 32; i++) begin
        @(negedge dco_clk);
        if (tap_up) begin ups++; run++; if (run > maxrun) maxrun = run; end
        else run = 0;
      end
      chk("R7", ups == it.ups_exp, ups, it.ups_exp);
      if (it.spread) chk("R8", maxrun <= 1, maxrun, 1);
      sb_done++;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(REF_PERIOD * 4000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int e0, e1, v0;
    rst_n = 0; wr_en = 0; wr_data = '0;
    mult_n = 7'd31; div_sel = 2'd1; mult_plus = 0;
    #1000;
    chk("R1", integ == 0, int'(integ), 0);
    chk("R1", tap == 0, int'(tap), 0);
    chk("R1", tap_up == 0, int'(tap_up), 0);
    @(negedge ref_clk);
    rst_n = 1;
    wait_ref(4);

    // exact 32:1 ratio: count equals target
    write_integ(10'h155);
    wait_ref(6);
    chk("R6", integ == 10'h155, int'(integ), 'h155);
    wait_ref(8);
    chk("R6", integ == 10'h155, int'(integ), 'h155);

    // DCO twice too fast -> step down
    dco_half = 25.0;
    wait_ref(2);
    write_integ(10'h200);
    watch_steps("R2", -1, 10);
    chk("R2", integ < 10'h200 && integ >= 10'h200 - 11, int'(integ), 'h200 - 10);

    // DCO twice too slow -> step up
    dco_half = 100.0;
    wait_ref(2);
    write_integ(10'h200);
    watch_steps("R2", 1, 10);
    chk("R2", integ > 10'h200 && integ <= 10'h200 + 11, int'(integ), 'h200 + 10);

    // saturation at both ends
    dco_half = 25.0;
    wait_ref(2);
    write_integ(3);
    wait_ref(12);
    chk("R4", integ == 0, int'(integ), 0);
    dco_half = 100.0;
    wait_ref(2);
    write_integ(1020);
    wait_ref(12);
    chk("R4", integ == 10'd1023, int'(integ), 1023);

    // target arithmetic
    dco_half = 50.0;
    mult_plus = 1; div_sel = 2'd3; mult_n = 7'd3;   // 4 * 8 = 32
    wait_ref(3);
    write_integ(10'h100);
    wait_ref(8);
    chk("R3", integ == 10'h100, int'(integ), 'h100);
    mult_plus = 0;                                  // target 4, count 32
    v0 = int'(integ);
    wait_ref(8);
    chk("R3", int'(integ) < v0, int'(integ), v0 - 7);
    mult_plus = 1; div_sel = 2'd0; mult_n = 7'd31;  // 32 * 1
    wait_ref(3);
    write_integ(10'h100);
    wait_ref(8);
    chk("R3", integ == 10'h100, int'(integ), 'h100);

    // modulator patterns through the scoreboard
    mult_plus = 0; div_sel = 2'd1; mult_n = 7'd31;
    wait_ref(3);
    sb_push(10'h000);
    sb_push(10'h0A5);
    sb_push(10'h1F0);
    sb_push(10'h1FF);
    sb_push(10'h36B);
    sb_push(10'h39F);
    sb_push(10'h3E7);

    // closed loop with oscillator model
    write_integ(0);
    model_en = 1;
    wait_ref(1500);
    chk("R10", integ >= 10'd760 && integ <= 10'd840, int'(integ), 800);
    @(posedge ref_clk); e0 = dco_edges;
    @(posedge ref_clk); e1 = dco_edges;
    chk("R10", (e1 - e0) >= 30 && (e1 - e0) <= 34, e1 - e0, 32);

    finish_run();
  end
endmodule